// File: doc/BRIEF.md
# System Clock Mode Controller

This block chooses where the CPU clock and the bus clocks come from, in one of three operating modes. In run mode the CPU takes the PLL output and the bus dividers derive the slower bus clocks from that rate. In direct-run mode every clock comes straight from the reference system clock, nominally around 13 MHz, though the exact rate depends on the oscillator source. In halt mode the system clock is gated off entirely, and only the always-on low-speed domain (real-time clock, touch and key scanning at about 32 kHz) keeps running, outside this block.

The controller reads a run-select bit and a stop bit from a control word, a PLL-lock indication, and a vector of wake events with a per-source enable vector. It drives the clock-source select, one gate enable for each source, the bus-divider enable, a grant saying the PLL may be reconfigured, and a two-bit mode code. The allowed transitions form a fixed graph. Halt and run are never adjacent. A wake from halt always lands in direct-run. The PLL may only be touched while the system runs from the reference. Every source change passes through a dead interval of `GAP_CYC` cycles in which both sources are gated, so the two clocks never overlap.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After synchronous reset the block is in direct-run: mode 2'b01, reference gate on, PLL gate off, select 0, bus dividers off, PLL reconfiguration grant on.
- R2: The mode code is 2'b10 in run, 2'b00 in halt and 2'b01 otherwise, including both dead intervals of a source switch.
- R3: With run-select set, the block leaves direct-run toward run only in a cycle where pll_lock is high. While lock stays low it remains in direct-run.
- R4: A change of clock source gates both sources for exactly GAP_CYC cycles, and the select toggles only while both are off. The new source's gate rises after that interval, so run is reached GAP_CYC+1 cycles after the request is seen.
- R5: In run the PLL gate, the select (1 = PLL) and the bus-divider enable are all high and the reference gate is low. In direct-run the reference gate is high and the other three are low.
- R6: Clearing run-select, losing lock or an armed stop request while in run (or during the switch toward it) returns the block to direct-run through a dead interval. Run never moves straight to halt, nor halt straight to run.
- R7: From direct-run, an armed stop request enters halt on the next edge. In halt all gates, the select and the bus-divider enable are low.
- R8: In halt, a cycle with (wake_evt & wake_en) nonzero moves the block to direct-run on the next edge. Disabled events keep it halted, and wake events outside halt change nothing.
- R9: Entering halt disarms the stop bit. Only a cycle with stop_req low re-arms it, so a stop bit still set after wake does not halt again.
- R10: The PLL reconfiguration grant is high only in steady direct-run, never while the PLL gate is on or during a switch.
- R11: While halted, run-select and pll_lock have no effect on the mode or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| run_sel | input | 1 | Control word bit: request run mode |
| stop_req | input | 1 | Control word bit: request halt |
| pll_lock | input | 1 | PLL locked indication |
| wake_evt | input | N_WAKE | Wake event per source |
| wake_en | input | N_WAKE | Wake enable per source |
| cpu_sel_pll | output | 1 | Clock source select, 1 = PLL, 0 = reference |
| ref_gate_en | output | 1 | Reference clock gate enable |
| pll_gate_en | output | 1 | PLL clock gate enable |
| bus_div_en | output | 1 | Bus clock dividers active |
| pll_cfg_ok | output | 1 | PLL may be enabled, changed or disabled |
| mode_o | output | 2 | Mode: 10 run, 01 direct-run, 00 halt |

## Verification
Every output is decoded from registered state, so a change of input takes effect at the first rising edge after it is driven. Halt entry and wake are due one cycle after the stimulus. Run is due GAP_CYC+1 cycles after a locked run request, preceded by GAP_CYC cycles with both gates low, and direct-run returns the same number of cycles after a run exit. Inputs are driven just after a falling edge, and all outputs are compared at the next falling edge against a reference model advanced on the rising edge. Every dead cycle and every landing cycle is therefore checked at the exact cycle it is due.

// File: rtl/sysclk_mode_pkg.sv
package sysclk_mode_pkg;

    typedef enum logic [2:0] {
        PS_HALT   = 3'd0,
        PS_DIRECT = 3'd1,
        PS_GAP_UP = 3'd2,
        PS_RUN    = 3'd3,
        PS_GAP_DN = 3'd4
    } pwr_state_e;

    localparam logic [1:0] MODE_HALT   = 2'b00;
    localparam logic [1:0] MODE_DIRECT = 2'b01;
    localparam logic [1:0] MODE_RUN    = 2'b10;

    typedef struct packed {
        logic       ref_en;
        logic       pll_en;
        logic       sel_pll;
        logic       div_en;
        logic       cfg_ok;
        logic [1:0] mode;
    } clk_ctrl_t;

    // Output pattern for each controller state
    function automatic clk_ctrl_t decode_state(pwr_state_e s);
        clk_ctrl_t c;
        c = '{ref_en: 1'b0, pll_en: 1'b0, sel_pll: 1'b0, div_en: 1'b0,
              cfg_ok: 1'b0, mode: MODE_DIRECT};
        case (s)
            PS_HALT:   c.mode = MODE_HALT;
            PS_DIRECT: begin
                c.ref_en = 1'b1;
                c.cfg_ok = 1'b1;
            end
            PS_GAP_UP: c.sel_pll = 1'b1;
            PS_RUN: begin
                c.pll_en  = 1'b1;
                c.sel_pll = 1'b1;
                c.div_en  = 1'b1;
                c.mode    = MODE_RUN;
            end
            default: c.mode = MODE_DIRECT;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/scm_wake_detect.sv
module scm_wake_detect #(
    parameter int N_WAKE = 8
) (
    input  logic [N_WAKE-1:0] wake_evt,
    input  logic [N_WAKE-1:0] wake_en,
    output logic              wake_hit
);
    logic [N_WAKE-1:0] masked;

    for (genvar i = 0; i < N_WAKE; i++) begin : g_mask
        assign masked[i] = wake_evt[i] & wake_en[i];
    end

    assign wake_hit = |masked;
endmodule

// File: rtl/scm_mode_fsm.sv
module scm_mode_fsm
    import sysclk_mode_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_sel,
    input  logic       stop_req,
    input  logic       pll_lock,
    input  logic       wake_hit,
    output pwr_state_e state_o
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CYC - 1);

    pwr_state_e    st;
    logic [CW-1:0] cnt;
    logic          armed;
    logic          halt_req;
    logic          leave_pll;

    assign halt_req  = stop_req & armed;
    assign leave_pll = ~run_sel | ~pll_lock | halt_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PS_DIRECT;
            cnt   <= '0;
            armed <= 1'b1;
        end else begin
            if (!stop_req) armed <= 1'b1;
            case (st)
                PS_HALT: begin
                    if (wake_hit) st <= PS_DIRECT;
                end
                PS_DIRECT: begin
                    if (halt_req) begin
                        st    <= PS_HALT;
                        armed <= 1'b0;
                    end else if (run_sel && pll_lock) begin
                        st  <= PS_GAP_UP;
                        cnt <= GAP_LOAD;
                    end
                end
                PS_GAP_UP: begin
                    if (leave_pll) begin
                        st  <= PS_GAP_DN;
                        cnt <= GAP_LOAD;
                    end else if (cnt == '0) begin
                        st <= PS_RUN;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PS_RUN: begin
                    if (leave_pll) begin
                        st  <= PS_GAP_DN;
                        cnt <= GAP_LOAD;
                    end
                end
                PS_GAP_DN: begin
                    if (cnt == '0) st <= PS_DIRECT;
                    else           cnt <= cnt - CW'(1);
                end
                default: st <= PS_DIRECT;
            endcase
        end
    end

    assign state_o = st;
endmodule

// File: rtl/scm_gate_decode.sv
module scm_gate_decode
    import sysclk_mode_pkg::*;
(
    input  pwr_state_e state_i,
    output clk_ctrl_t  ctrl_o
);
    always_comb ctrl_o = decode_state(state_i);
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
    import sysclk_mode_pkg::*;
#(
    parameter int N_WAKE  = 8,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_sel,
    input  logic              stop_req,
    input  logic              pll_lock,
    input  logic [N_WAKE-1:0] wake_evt,
    input  logic [N_WAKE-1:0] wake_en,
    output logic              cpu_sel_pll,
    output logic              ref_gate_en,
    output logic              pll_gate_en,
    output logic              bus_div_en,
    output logic              pll_cfg_ok,
    output logic [1:0]        mode_o
);
    logic       wake_hit;
    pwr_state_e state;
    clk_ctrl_t  ctrl;

    scm_wake_detect #(.N_WAKE(N_WAKE)) u_wake (
        .wake_evt (wake_evt),
        .wake_en  (wake_en),
        .wake_hit (wake_hit)
    );

    scm_mode_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run_sel  (run_sel),
        .stop_req (stop_req),
        .pll_lock (pll_lock),
        .wake_hit (wake_hit),
        .state_o  (state)
    );

    scm_gate_decode u_dec (
        .state_i (state),
        .ctrl_o  (ctrl)
    );

    assign cpu_sel_pll = ctrl.sel_pll;
    assign ref_gate_en = ctrl.ref_en;
    assign pll_gate_en = ctrl.pll_en;
    assign bus_div_en  = ctrl.div_en;
    assign pll_cfg_ok  = ctrl.cfg_ok;
    assign mode_o      = ctrl.mode;
endmodule

// File: rtl/sysclk_mode_chk.sv
module sysclk_mode_chk
    import sysclk_mode_pkg::*;
#(
    parameter int N_WAKE = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pll_lock,
    input logic [N_WAKE-1:0] wake_evt,
    input logic [N_WAKE-1:0] wake_en,
    input logic              cpu_sel_pll,
    input logic              ref_gate_en,
    input logic              pll_gate_en,
    input logic              pll_cfg_ok,
    input logic [1:0]        mode_o
);
    // R6
    no_run_to_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_RUN) |=> (mode_o != MODE_HALT));

    // R6
    no_halt_to_run_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_HALT) |=> (mode_o != MODE_RUN));

    // R4
    sel_dead_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel_pll != $past(cpu_sel_pll)) |-> (!ref_gate_en && !pll_gate_en));

    // R4
    pll_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_gate_en) |-> $past(!ref_gate_en));

    // R3
    pll_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_gate_en) |-> $past(pll_lock));

    // R10
    cfg_off_pll_chk: assert property (@(posedge clk) disable iff (rst)
        pll_cfg_ok |-> (!pll_gate_en && ref_gate_en && mode_o == MODE_DIRECT));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_HALT && (wake_evt & wake_en) == '0) |=> (mode_o == MODE_HALT));

    // R8
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_HALT && (wake_evt & wake_en) != '0) |=> (mode_o == MODE_DIRECT));
endmodule

bind sysclk_mode_ctrl sysclk_mode_chk #(.N_WAKE(N_WAKE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pll_lock    (pll_lock),
    .wake_evt    (wake_evt),
    .wake_en     (wake_en),
    .cpu_sel_pll (cpu_sel_pll),
    .ref_gate_en (ref_gate_en),
    .pll_gate_en (pll_gate_en),
    .pll_cfg_ok  (pll_cfg_ok),
    .mode_o      (mode_o)
);

// File: tb/sim_sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_mode_ctrl;
    localparam int NW  = 8;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_sel = 1'b0, stop_req = 1'b0, pll_lock = 1'b0;
    logic [NW-1:0] wake_evt = '0, wake_en = '0;
    logic cpu_sel_pll, ref_gate_en, pll_gate_en, bus_div_en, pll_cfg_ok;
    logic [1:0] mode_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    sysclk_mode_ctrl #(.N_WAKE(NW), .GAP_CYC(GAP)) u0 (
        .clk(clk), .rst(rst), .run_sel(run_sel), .stop_req(stop_req),
        .pll_lock(pll_lock), .wake_evt(wake_evt), .wake_en(wake_en),
        .cpu_sel_pll(cpu_sel_pll), .ref_gate_en(ref_gate_en),
        .pll_gate_en(pll_gate_en), .bus_div_en(bus_div_en),
        .pll_cfg_ok(pll_cfg_ok), .mode_o(mode_o)
    );

    // Reference model: where 'pos' is 0 halted, 1 on reference,
    // 2 dead heading to PLL, 3 on PLL, 4 dead heading to reference
    int pos = 1;
    int dead_left = 0;
    bit may_halt = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            pos = 1; dead_left = 0; may_halt = 1'b1;
        end else begin
            bit want_halt;
            bit quit_pll;
            want_halt = stop_req && may_halt;
            quit_pll  = !run_sel || !pll_lock || want_halt;
            if (pos == 0) begin
                if ((wake_evt & wake_en) != 0) pos = 1;
            end else if (pos == 1) begin
                if (want_halt) begin pos = 0; may_halt = 1'b0; end
                else if (run_sel && pll_lock) begin pos = 2; dead_left = GAP; end
            end else if (pos == 2) begin
                if (quit_pll) begin pos = 4; dead_left = GAP; end
                else begin dead_left--; if (dead_left == 0) pos = 3; end
            end else if (pos == 3) begin
                if (quit_pll) begin pos = 4; dead_left = GAP; end
            end else begin
                dead_left--; if (dead_left == 0) pos = 1;
            end
            if (!stop_req) may_halt = 1'b1;
        end
    end

    // Compare all outputs with the model every cycle, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [6:0] exp_v, act_v;
            exp_v = {pos == 1, pos == 3, (pos == 2 || pos == 3), pos == 3, pos == 1,
                     (pos == 3) ? 2'b10 : ((pos == 0) ? 2'b00 : 2'b01)};
            act_v = {ref_gate_en, pll_gate_en, cpu_sel_pll, bus_div_en, pll_cfg_ok, mode_o};
            checks++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s cycle %0d: outputs %b expected %b", tag, cyc, act_v, exp_v);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_mode(input logic [1:0] m, input string req);
        checks++;
        if (mode_o !== m) begin
            fails++;
            $display("FAIL %s: mode %b expected %b", req, mode_o, m);
        end
    endtask

    task automatic expect_bit(input logic a, input logic e, input string req);
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s: value %b expected %b", req, a, e);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: cycle %0d expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        tag = "R1";
        expect_mode(2'b01, "R1");
        expect_bit(ref_gate_en, 1'b1, "R1");
        expect_bit(pll_cfg_ok, 1'b1, "R1");

        // R3: run request without lock stays on reference
        tag = "R3"; run_sel = 1'b1;
        wait_cyc(5);
        expect_mode(2'b01, "R3");
        expect_bit(pll_gate_en, 1'b0, "R3");

        // R4/R5: lock arrives, dead interval then run
        tag = "R4"; pll_lock = 1'b1;
        wait_cyc(1);
        expect_bit(ref_gate_en | pll_gate_en, 1'b0, "R4");
        expect_mode(2'b01, "R2");
        expect_bit(pll_cfg_ok, 1'b0, "R10");
        wait_cyc(GAP);
        tag = "R5";
        expect_mode(2'b10, "R5");
        expect_bit(bus_div_en, 1'b1, "R5");
        wait_cyc(3);

        // R6: lock loss drops back to reference
        tag = "R6"; pll_lock = 1'b0;
        wait_cyc(1);
        expect_mode(2'b01, "R6");
        wait_cyc(GAP);
        expect_bit(ref_gate_en, 1'b1, "R6");

        // Back to run, then clear run_sel
        pll_lock = 1'b1;
        wait_cyc(GAP + 3);
        expect_mode(2'b10, "R5");
        run_sel = 1'b0;
        wait_cyc(GAP + 1);
        expect_mode(2'b01, "R6");

        // Run again, then stop request from run: via reference to halt
        run_sel = 1'b1;
        wait_cyc(GAP + 3);
        tag = "R7"; stop_req = 1'b1;
        wait_cyc(1);
        expect_mode(2'b01, "R6");
        wait_cyc(GAP + 1);
        expect_mode(2'b00, "R7");
        expect_bit(ref_gate_en | pll_gate_en | cpu_sel_pll | bus_div_en, 1'b0, "R7");

        // R11: run_sel and lock toggles while halted do nothing
        tag = "R11"; run_sel = 1'b0; pll_lock = 1'b0;
        wait_cyc(2);
        run_sel = 1'b1; pll_lock = 1'b1;
        wait_cyc(3);
        expect_mode(2'b00, "R11");
        run_sel = 1'b0;

        // R8: disabled wake ignored, enabled wake returns to direct-run
        tag = "R8"; wake_en = 8'b0000_0101; wake_evt = 8'b1010_0000;
        wait_cyc(3);
        expect_mode(2'b00, "R8");
        wake_evt = 8'b0000_0100;
        wait_cyc(1);
        expect_mode(2'b01, "R8");
        wake_evt = '0;

        // R9: stop bit still set does not halt again until cleared
        tag = "R9";
        wait_cyc(4);
        expect_mode(2'b01, "R9");
        stop_req = 1'b0;
        wait_cyc(2);
        expect_mode(2'b01, "R9");
        stop_req = 1'b1;
        wait_cyc(1);
        expect_mode(2'b00, "R9");

        // Wake via bit 0, clear stop
        tag = "R8"; wake_evt = 8'b0000_0001;
        wait_cyc(1);
        wake_evt = '0; stop_req = 1'b0;
        expect_mode(2'b01, "R8");

        // R8: wake while not halted ignored
        wake_evt = 8'hFF; wake_en = 8'hFF;
        wait_cyc(3);
        expect_mode(2'b01, "R8");
        expect_bit(pll_cfg_ok, 1'b1, "R10");
        wake_evt = '0;

        // R6: abort during switch toward run
        tag = "R6"; run_sel = 1'b1; pll_lock = 1'b1;
        wait_cyc(1);
        run_sel = 1'b0;
        wait_cyc(1);
        expect_bit(pll_gate_en, 1'b0, "R6");
        wait_cyc(GAP + 2);
        expect_mode(2'b01, "R6");

        // R1: reset from run returns to direct-run
        run_sel = 1'b1;
        wait_cyc(GAP + 3);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0; run_sel = 1'b0;
        wait_cyc(1);
        tag = "R1";
        expect_mode(2'b01, "R1");
        expect_bit(pll_gate_en, 1'b0, "R1");
        wait_cyc(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule